// File: doc/BRIEF.md
# Microcode Control Store Access Sequencer

This block lets a microprogram read and rewrite its own writable control store. The store holds 36-bit microwords, each viewed as a 16-bit high half, a 16-bit low half and a 4-bit extra field. Software reaches one of these portions at a time through a 16-bit path. The portion is chosen with a 4-bit select input.

An access works like this. A load instruction puts the target address into an access-address register. A read or write command then takes the control store address bus for two cycles. After that, the bus goes back to the next-instruction address so that instruction fetch can continue. A write needs one more instruction before the address load: it latches the 16-bit write data, together with the 4-bit extra data, into a holding register.

Read data stays on the 16-bit result bus until a later read or an address read-back replaces it. An address load that carries the restore option also pulses an active-low restore strobe. A behavioural RAM model of the store is part of the block.

Top module: `ucs_access_seq`

## Requirements
- R1: While reset is high, and after it is released, the result bus is 0, the restore strobe is high and the sequencer is idle.
- R2: Command code 1 (load) and command code 2 (load with restore) copy the 16-bit data input into the access-address register. Command code 6 (read back) puts that register's full 16-bit value on the result bus one clock edge later.
- R3: Command code 2 drives restore_n low for exactly the one cycle that follows its clock edge.
- R4: When no access is in progress, the address bus carries the complement of the 12-bit next-instruction address input.
- R5: Command code 4 (read) holds the complement of the low 12 bits of the access-address register on the address bus for the two cycles after its edge. The selected portion appears on the result bus after the second edge that follows.
- R6: When an access completes, the address bus returns to the next-instruction address. The result bus keeps its value until the next read completes or a read-back is issued.
- R7: Command code 3 (hold) latches the data input as write data and the select input as extra-field data. Command code 5 (write) drives the access address for two cycles and then stores the held data.
- R8: The select value is sampled with the read or write command. Code 0 chooses the high half, 1 the low half and 3 the extra field. Any other code reads as 0 and writes nothing.
- R9: A read of the extra field returns it in bits 3:0 of the result, with bits 15:4 zero.
- R10: A write changes only the selected portion of the addressed word.
- R11: Any command presented during the two access cycles is ignored, including address loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_in | input | 3 | Command: 0 none, 1 load, 2 load with restore, 3 hold, 4 read, 5 write, 6 read back |
| data_in | input | 16 | Address for loads, write data for hold |
| sel_in | input | 4 | Portion select for read/write; extra-field data for hold |
| next_pc | input | 12 | Next-instruction address for fetch |
| cs_addr_n | output | 12 | Control store address bus, active low |
| result | output | 16 | Read data or access-address read-back |
| restore_n | output | 1 | Restore strobe, active low |

## Verification
Commands are applied just after a falling edge and take effect at the next rising edge. Every output is sampled at the falling edge that follows. An access-address load shows up one edge later. The address bus carries the access address in the first and second cycles after a read or write is issued. Read data is due, and the bus is back on the next-instruction address, at the falling edge two cycles after that. The checks then sample one more cycle to confirm that the result holds through the following fetch. Restore is checked low in the single cycle after its load and high in the cycle after that.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
    localparam int CS_AW  = 12;
    localparam int HALF_W = 16;
    localparam int EXT_W  = 4;
    localparam int SEL_W  = 4;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_LOAD  = 3'd1,
        OP_LDRST = 3'd2,
        OP_HOLD  = 3'd3,
        OP_READ  = 3'd4,
        OP_WRITE = 3'd5,
        OP_PEEK  = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC1 = 2'd1,
        ST_ACC2 = 2'd2
    } seq_e;

    localparam logic [SEL_W-1:0] SEL_HI  = 4'd0;
    localparam logic [SEL_W-1:0] SEL_LO  = 4'd1;
    localparam logic [SEL_W-1:0] SEL_EXT = 4'd3;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
        logic [EXT_W-1:0]  ext;
    } uword_t;

    function automatic logic sel_valid(input logic [SEL_W-1:0] s);
        return (s == SEL_HI) || (s == SEL_LO) || (s == SEL_EXT);
    endfunction

    function automatic logic [HALF_W-1:0] pick_portion(input uword_t w,
                                                       input logic [SEL_W-1:0] s);
        logic [HALF_W-1:0] r;
        r = '0;
        case (s)
            SEL_HI:  r = w.hi;
            SEL_LO:  r = w.lo;
            SEL_EXT: r[EXT_W-1:0] = w.ext;
            default: r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ucs_seq_fsm.sv
module ucs_seq_fsm
    import ucs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  op,
    output seq_e state,
    output logic idle,
    output logic wr_q,
    output logic fin
);
    seq_e state_nx;
    logic start;

    assign idle  = (state == ST_IDLE);
    assign start = idle && ((op == OP_READ) || (op == OP_WRITE));
    assign fin   = (state == ST_ACC2);

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (start) state_nx = ST_ACC1;
            ST_ACC1: state_nx = ST_ACC2;
            ST_ACC2: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            wr_q  <= 1'b0;
        end else begin
            state <= state_nx;
            if (start) wr_q <= (op == OP_WRITE);
        end
    end
endmodule

// File: rtl/ucs_access_regs.sv
module ucs_access_regs
    import ucs_pkg::*;
#(
    parameter int DW = HALF_W,
    parameter int XW = EXT_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          idle,
    input  op_e           op,
    input  logic [DW-1:0] data_in,
    input  logic [SW-1:0] sel_in,
    output logic [DW-1:0] acc_addr,
    output logic [DW-1:0] hold_data,
    output logic [XW-1:0] hold_ext,
    output logic [SW-1:0] sel_q,
    output logic          restore_q
);
    logic ld_en, hold_en, sel_en;

    assign ld_en   = idle && ((op == OP_LOAD) || (op == OP_LDRST));
    assign hold_en = idle && (op == OP_HOLD);
    assign sel_en  = idle && ((op == OP_READ) || (op == OP_WRITE));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_addr  <= '0;
            hold_data <= '0;
            hold_ext  <= '0;
            sel_q     <= '0;
            restore_q <= 1'b0;
        end else begin
            if (ld_en)   acc_addr <= data_in;
            if (hold_en) begin
                hold_data <= data_in;
                hold_ext  <= sel_in[XW-1:0];
            end
            if (sel_en)  sel_q <= sel_in;
            restore_q <= idle && (op == OP_LDRST);
        end
    end
endmodule

// File: rtl/ucs_cs_ram.sv
module ucs_cs_ram
    import ucs_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = HALF_W,
    parameter int XW = EXT_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [XW-1:0] wext,
    output uword_t        rword
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] hi_mem  [DEPTH];
    logic [DW-1:0] lo_mem  [DEPTH];
    logic [XW-1:0] ext_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            case (wsel)
                SEL_HI:  hi_mem[addr]  <= wdata;
                SEL_LO:  lo_mem[addr]  <= wdata;
                SEL_EXT: ext_mem[addr] <= wext;
                default: ;
            endcase
        end
    end

    always_comb begin
        rword.hi  = hi_mem[addr];
        rword.lo  = lo_mem[addr];
        rword.ext = ext_mem[addr];
    end
endmodule

// File: rtl/ucs_access_seq.sv
module ucs_access_seq
    import ucs_pkg::*;
#(
    parameter int ADDR_W = CS_AW,
    parameter int DATA_W = HALF_W,
    parameter int RAM_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [ADDR_W-1:0] next_pc,
    output logic [ADDR_W-1:0] cs_addr_n,
    output logic [DATA_W-1:0] result,
    output logic              restore_n
);
    localparam int RAM_USE = (RAM_AW < ADDR_W) ? RAM_AW : ADDR_W;

    op_e               op;
    seq_e              state_q;
    logic              idle, wr_q, fin, fin_rd, peek_go, ram_we, restore_q;
    logic [DATA_W-1:0] acc_addr, hold_data;
    logic [EXT_W-1:0]  hold_ext;
    logic [SEL_W-1:0]  sel_q;
    uword_t            ram_word;

    assign op = op_e'(op_in);

    ucs_seq_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .state (state_q),
        .idle  (idle),
        .wr_q  (wr_q),
        .fin   (fin)
    );

    ucs_access_regs #(.DW(DATA_W), .XW(EXT_W), .SW(SEL_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .idle      (idle),
        .op        (op),
        .data_in   (data_in),
        .sel_in    (sel_in),
        .acc_addr  (acc_addr),
        .hold_data (hold_data),
        .hold_ext  (hold_ext),
        .sel_q     (sel_q),
        .restore_q (restore_q)
    );

    assign ram_we = fin && wr_q && sel_valid(sel_q);

    ucs_cs_ram #(.AW(RAM_USE), .DW(DATA_W), .XW(EXT_W), .SW(SEL_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .wsel  (sel_q),
        .addr  (acc_addr[RAM_USE-1:0]),
        .wdata (hold_data),
        .wext  (hold_ext),
        .rword (ram_word)
    );

    assign fin_rd  = fin && !wr_q;
    assign peek_go = idle && (op == OP_PEEK);

    always_ff @(posedge clk) begin
        if (rst)          result <= '0;
        else if (fin_rd)  result <= pick_portion(ram_word, sel_q);
        else if (peek_go) result <= acc_addr;
    end

    assign cs_addr_n = idle ? ~next_pc : ~acc_addr[ADDR_W-1:0];
    assign restore_n = ~restore_q;
endmodule

// File: rtl/ucs_access_chk.sv
module ucs_access_chk
    import ucs_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [2:0]  op_in,
    input logic [15:0] data_in,
    input logic        restore_n,
    input logic [15:0] result,
    input logic [1:0]  state,
    input logic [15:0] acc_addr,
    input logic        fin_rd,
    input logic        peek_go
);
    assert_load_copies_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && (op_in == 3'd1 || op_in == 3'd2)) |=> acc_addr == $past(data_in));

    assert_restore_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        !restore_n |=> restore_n);

    assert_restore_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(restore_n) |-> $past(op_in) == 3'd2);

    assert_two_cycle_access_R5: assert property (@(posedge clk) disable iff (rst)
        state == ST_ACC1 |=> state == ST_ACC2);

    assert_access_ends_R6: assert property (@(posedge clk) disable iff (rst)
        state == ST_ACC2 |=> state == ST_IDLE);

    assert_result_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (!fin_rd && !peek_go) |=> $stable(result));

    assert_addr_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        state != ST_IDLE |=> $stable(acc_addr));
endmodule

bind ucs_access_seq ucs_access_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_in     (op_in),
    .data_in   (data_in),
    .restore_n (restore_n),
    .result    (result),
    .state     (state_q),
    .acc_addr  (acc_addr),
    .fin_rd    (fin_rd),
    .peek_go   (peek_go)
);

// File: tb/sim_ucs_access_seq.sv
module sim_ucs_access_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_in = 3'd0;
    logic [15:0] data_in = '0;
    logic [3:0]  sel_in = '0;
    logic [11:0] next_pc = 12'h112;
    logic [11:0] cs_addr_n;
    logic [15:0] result;
    logic        restore_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ucs_access_seq u0 (
        .clk       (clk),
        .rst       (rst),
        .op_in     (op_in),
        .data_in   (data_in),
        .sel_in    (sel_in),
        .next_pc   (next_pc),
        .cs_addr_n (cs_addr_n),
        .result    (result),
        .restore_n (restore_n)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(logic [2:0] op, logic [15:0] d, logic [3:0] s);
        @(negedge clk);
        op_in = op; data_in = d; sel_in = s;
        @(negedge clk);
        op_in = 3'd0;
    endtask

    task automatic write_word(logic [15:0] addr, logic [3:0] sel,
                              logic [15:0] d, logic [3:0] x);
        issue(3'd3, d, x);
        issue(3'd1, addr, 4'd0);
        issue(3'd5, 16'h0, sel);
        check("R7 write cycle1 bus", {4'h0, cs_addr_n}, {4'h0, ~addr[11:0]});
        @(negedge clk);
        check("R7 write cycle2 bus", {4'h0, cs_addr_n}, {4'h0, ~addr[11:0]});
        @(negedge clk);
        check("R6 bus after write", {4'h0, cs_addr_n}, {4'h0, ~next_pc});
    endtask

    task automatic read_word(string req, logic [15:0] addr, logic [3:0] sel,
                             logic [15:0] exp);
        issue(3'd1, addr, 4'd0);
        issue(3'd4, 16'h0, sel);
        check("R5 read cycle1 bus", {4'h0, cs_addr_n}, {4'h0, ~addr[11:0]});
        @(negedge clk);
        check("R5 read cycle2 bus", {4'h0, cs_addr_n}, {4'h0, ~addr[11:0]});
        @(negedge clk);
        check(req, result, exp);
        check("R6 bus after read", {4'h0, cs_addr_n}, {4'h0, ~next_pc});
        @(negedge clk);
        check("R6 result held", result, exp);
    endtask

    task automatic t_reset;
        check("R1 result", result, 16'h0);
        check("R1 restore", {15'h0, restore_n}, 16'h1);
        check("R4 idle bus", {4'h0, cs_addr_n}, {4'h0, ~next_pc});
    endtask

    task automatic t_load_peek;
        issue(3'd1, 16'hC203, 4'd0);
        issue(3'd6, 16'h0, 4'd0);
        check("R2 read back", result, 16'hC203);
        next_pc = 12'h2A5;
        @(negedge clk);
        check("R4 new next_pc", {4'h0, cs_addr_n}, {4'h0, ~12'h2A5});
    endtask

    task automatic t_restore;
        check("R3 idle high", {15'h0, restore_n}, 16'h1);
        issue(3'd2, 16'h0040, 4'd0);
        check("R3 low after load", {15'h0, restore_n}, 16'h0);
        @(negedge clk);
        check("R3 high again", {15'h0, restore_n}, 16'h1);
        issue(3'd6, 16'h0, 4'd0);
        check("R2 restore load value", result, 16'h0040);
        issue(3'd1, 16'h0041, 4'd0);
        check("R3 plain load no strobe", {15'h0, restore_n}, 16'h1);
    endtask

    task automatic t_portions;
        next_pc = 12'h112;
        write_word(16'h0200, 4'd0, 16'hAAAA, 4'h5);
        write_word(16'h0200, 4'd1, 16'h1234, 4'h6);
        write_word(16'h0200, 4'd3, 16'hFFFF, 4'hA);
        read_word("R8 high half", 16'h0200, 4'd0, 16'hAAAA);
        read_word("R8 low half", 16'h0200, 4'd1, 16'h1234);
        read_word("R9 extra field", 16'h0200, 4'd3, 16'h000A);
        read_word("R8 invalid select reads 0", 16'h0200, 4'd2, 16'h0000);
    endtask

    task automatic t_partial_write;
        write_word(16'h0200, 4'd0, 16'h5555, 4'h3);
        read_word("R10 high rewritten", 16'h0200, 4'd0, 16'h5555);
        read_word("R10 low kept", 16'h0200, 4'd1, 16'h1234);
        read_word("R10 extra kept", 16'h0200, 4'd3, 16'h000A);
        write_word(16'h0200, 4'd2, 16'h0F0F, 4'h1);
        read_word("R8 invalid select writes nothing hi", 16'h0200, 4'd0, 16'h5555);
        read_word("R8 invalid select writes nothing ext", 16'h0200, 4'd3, 16'h000A);
        write_word(16'h0013, 4'd1, 16'hBEEF, 4'h0);
        read_word("R7 second address", 16'h0013, 4'd1, 16'hBEEF);
        read_word("R10 other address untouched", 16'h0200, 4'd1, 16'h1234);
    endtask

    task automatic t_ignore;
        issue(3'd1, 16'h0200, 4'd0);
        issue(3'd4, 16'h0, 4'd1);
        op_in = 3'd1; data_in = 16'h03FF; sel_in = 4'd0;
        @(negedge clk);
        check("R11 bus kept during access", {4'h0, cs_addr_n}, {4'h0, ~12'h200});
        op_in = 3'd2; data_in = 16'h0111;
        @(negedge clk);
        op_in = 3'd0;
        check("R11 read unaffected", result, 16'h1234);
        check("R11 no restore during access", {15'h0, restore_n}, 16'h1);
        issue(3'd6, 16'h0, 4'd0);
        check("R11 address kept", result, 16'h0200);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 result during reset", result, 16'h0);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load_peek();
        t_restore();
        t_portions();
        t_partial_write();
        t_ignore();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule